// File: doc/BRIEF.md
# Radix Tree Node Key Lookup

This block searches a single node of an adaptive radix tree for one 8-bit key byte and answers with the matching child pointer, or with a miss. The whole node is presented in parallel on the request side: a kind code, a packed array of stored keys with a valid-key count, a 256-entry byte index and a packed array of child pointers. A traversal engine around the block fetches the node, issues one request per tree level and consumes the answer.

Nodes with room for 4 or 16 children are searched by comparing every stored key with the search byte at once. The position of the matching key selects the child pointer. The 48-child node is searched indirectly. The search byte addresses the index, which yields a slot number. The slot number then selects the pointer. The indirect path spends one extra cycle, and the block is not ready during that cycle.

Top module: `art_node_lookup`

## Requirements
- R1: Kind code 0 is a 4-child node, 1 a 16-child node, 2 a 48-child node and 3 is invalid. A hit in a 4- or 16-child node at key position i returns pointer entry i with hit set. The response is valid in the cycle after the request is accepted.
- R2: In a 4- or 16-child node only key positions below min(count, capacity) take part in matching. Capacity is 4 or 16.
- R3: A miss of any kind returns hit low and a pointer of zero. Error is never set together with hit.
- R4: When several enabled key positions hold the search byte, the lowest position wins.
- R5: For a 48-child node, the index entry at the search byte gives a slot. The pointer entry at that slot is returned with hit set. The response is valid two cycles after acceptance and not in the cycle between.
- R6: In a 48-child node, an index entry of 0xFF marks an absent key and gives a miss. Any other entry of 48 or above also gives a miss. Neither case sets error.
- R7: Kind code 3 gives a miss with error set, one cycle after acceptance.
- R8: req_ready is low in the cycle that follows the acceptance of a 48-child request. A request presented while req_ready is low is not accepted and produces no response.
- R9: During and right after reset, rsp_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_kind | input | 2 | Node kind code |
| req_count | input | 5 | Number of valid stored keys (small nodes) |
| req_key | input | 8 | Search byte |
| node_keys | input | 128 | Stored keys, position i in bits [8i+7:8i] |
| node_index | input | 2048 | Index, entry k in bits [8k+7:8k] |
| node_ptrs | input | 768 | Child pointers, entry s in bits [16s+15:16s] |
| rsp_valid | output | 1 | Response valid (one-cycle pulse) |
| rsp_hit | output | 1 | Key found |
| rsp_err | output | 1 | Invalid node kind |
| rsp_ptr | output | 16 | Child pointer, zero on a miss |

## Verification
A stuck or mistimed busy state can show at the ports in two ways. In one, req_ready stays low past the single gap cycle. In the other, a 48-child answer arrives one cycle early or late. Both are visible on the first such request. A wrong stored slot or a wrong slot-valid flag returns the wrong pointer, or flips hit, on the very response that used it. The vector set therefore mixes slots at both ends of the pointer array with empty and out-of-range index entries. An error in the small-node enable mask or in the priority encoding only shows for keys at the count boundary or for duplicated keys, so those cases are driven directly.

// File: rtl/art_pkg.sv
package art_pkg;

    localparam int unsigned KEY_W = 8;

    typedef enum logic [1:0] {
        NODE_K4  = 2'd0,
        NODE_K16 = 2'd1,
        NODE_K48 = 2'd2,
        NODE_BAD = 2'd3
    } node_kind_e;

    typedef struct packed {
        logic hit;
        logic err;
    } lookup_flags_t;

    localparam logic [KEY_W-1:0] SLOT_EMPTY = '1;

    // Number of key positions enabled for a small node of the given kind.
    function automatic int unsigned enabled_keys(
        input node_kind_e   kind,
        input int unsigned  count,
        input int unsigned  cap_a,
        input int unsigned  cap_b
    );
        int unsigned cap;
        case (kind)
            NODE_K4:  cap = cap_a;
            NODE_K16: cap = cap_b;
            default:  cap = 0;
        endcase
        return (count < cap) ? count : cap;
    endfunction

endpackage

// File: rtl/art_small_match.sv
module art_small_match #(
    parameter int unsigned SLOTS = 16,
    parameter int unsigned KW    = 8,
    parameter int unsigned CW    = 5,
    localparam int unsigned PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic [KW-1:0]       key,
    input  logic [SLOTS*KW-1:0] keys,
    input  logic [CW-1:0]       limit,
    output logic                hit,
    output logic [PW-1:0]       pos
);

    logic [SLOTS-1:0] eq;

    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
            assign eq[i] = (keys[i*KW +: KW] == key) && ((CW+1)'(i) < {1'b0, limit});
        end
    endgenerate

    always_comb begin
        pos = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (eq[i]) pos = PW'(i);
        end
    end

    assign hit = |eq;

endmodule

// File: rtl/art_index_stage.sv
module art_index_stage #(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned KW      = 8,
    parameter int unsigned SLOTS   = 48
) (
    input  logic [KW-1:0]         key,
    input  logic [ENTRIES*KW-1:0] index,
    output logic [KW-1:0]         slot,
    output logic                  slot_ok
);
    import art_pkg::*;

    assign slot    = index[key*KW +: KW];
    assign slot_ok = (slot != SLOT_EMPTY) && (int'(slot) < int'(SLOTS));

endmodule

// File: rtl/art_slot_read.sv
module art_slot_read #(
    parameter int unsigned SLOTS = 48,
    parameter int unsigned PTR_W = 16,
    localparam int unsigned SW   = $clog2(SLOTS)
) (
    input  logic [SW-1:0]          sel,
    input  logic [SLOTS*PTR_W-1:0] ptrs,
    output logic [PTR_W-1:0]       ptr
);

    always_comb begin
        ptr = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (sel == SW'(s)) ptr = ptrs[s*PTR_W +: PTR_W];
        end
    end

endmodule

// File: rtl/art_node_lookup.sv
module art_node_lookup #(
    parameter int unsigned CAP_A   = 4,
    parameter int unsigned CAP_B   = 16,
    parameter int unsigned SLOTS   = 48,
    parameter int unsigned PTR_W   = 16,
    localparam int unsigned KW      = art_pkg::KEY_W,
    localparam int unsigned ENTRIES = 2 ** KW,
    localparam int unsigned CW      = $clog2(CAP_B + 1),
    localparam int unsigned SW      = $clog2(SLOTS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [1:0]               req_kind,
    input  logic [CW-1:0]            req_count,
    input  logic [KW-1:0]            req_key,
    input  logic [CAP_B*KW-1:0]      node_keys,
    input  logic [ENTRIES*KW-1:0]    node_index,
    input  logic [SLOTS*PTR_W-1:0]   node_ptrs,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic                     rsp_err,
    output logic [PTR_W-1:0]         rsp_ptr
);
    import art_pkg::*;

    localparam int unsigned PW = (CAP_B > 1) ? $clog2(CAP_B) : 1;

    node_kind_e    kind;
    logic [CW-1:0] limit;
    logic          sm_hit;
    logic [PW-1:0] sm_pos;
    logic [KW-1:0] ix_slot;
    logic          ix_ok;
    logic          busy;
    logic [SW-1:0] slot_q;
    logic          slot_ok_q;
    logic [SW-1:0] rd_sel;
    logic [PTR_W-1:0] rd_ptr;
    logic          accept;
    lookup_flags_t flags_d;

    assign kind   = node_kind_e'(req_kind);
    assign limit  = CW'(enabled_keys(kind, int'(req_count), CAP_A, CAP_B));
    assign accept = req_valid && req_ready;
    assign req_ready = !busy;

    art_small_match #(.SLOTS(CAP_B), .KW(KW), .CW(CW)) u_small (
        .key   (req_key),
        .keys  (node_keys),
        .limit (limit),
        .hit   (sm_hit),
        .pos   (sm_pos)
    );

    art_index_stage #(.ENTRIES(ENTRIES), .KW(KW), .SLOTS(SLOTS)) u_index (
        .key     (req_key),
        .index   (node_index),
        .slot    (ix_slot),
        .slot_ok (ix_ok)
    );

    // One pointer mux shared by both paths.
    assign rd_sel = busy ? slot_q : SW'(sm_pos);

    art_slot_read #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_read (
        .sel  (rd_sel),
        .ptrs (node_ptrs),
        .ptr  (rd_ptr)
    );

    always_comb begin
        flags_d = '{hit: 1'b0, err: 1'b0};
        case (kind)
            NODE_K4, NODE_K16: flags_d.hit = sm_hit;
            NODE_BAD:          flags_d.err = 1'b1;
            default:           flags_d     = '{hit: 1'b0, err: 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            slot_q    <= '0;
            slot_ok_q <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_ptr   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (busy) begin
                busy      <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_hit   <= slot_ok_q;
                rsp_err   <= 1'b0;
                rsp_ptr   <= slot_ok_q ? rd_ptr : '0;
            end else if (accept) begin
                if (kind == NODE_K48) begin
                    busy      <= 1'b1;
                    slot_q    <= ix_slot[SW-1:0];
                    slot_ok_q <= ix_ok;
                end else begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= flags_d.hit;
                    rsp_err   <= flags_d.err;
                    rsp_ptr   <= flags_d.hit ? rd_ptr : '0;
                end
            end
        end
    end

endmodule

// File: rtl/art_node_lookup_chk.sv
module art_node_lookup_chk #(
    parameter int unsigned PTR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_kind,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_err,
    input logic [PTR_W-1:0] rsp_ptr
);

    logic acc_wide, acc_small, acc_bad;
    assign acc_wide  = req_valid && req_ready && (req_kind == 2'd2);
    assign acc_small = req_valid && req_ready && (req_kind < 2'd2);
    assign acc_bad   = req_valid && req_ready && (req_kind == 2'd3);

    // R1
    small_latency_chk: assert property (@(posedge clk) disable iff (rst)
        acc_small |=> rsp_valid && !rsp_err);

    // R5
    wide_latency_chk: assert property (@(posedge clk) disable iff (rst)
        acc_wide |=> !rsp_valid ##1 rsp_valid);

    // R3
    miss_ptr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_ptr == '0));

    // R3
    err_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_hit && rsp_err));

    // R7
    bad_kind_err_chk: assert property (@(posedge clk) disable iff (rst)
        acc_bad |=> rsp_valid && rsp_err && !rsp_hit);

    // R8
    ready_gap_chk: assert property (@(posedge clk) disable iff (rst)
        acc_wide |=> !req_ready ##1 req_ready);

    // R8
    no_long_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready);

endmodule

bind art_node_lookup art_node_lookup_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_err   (rsp_err),
    .rsp_ptr   (rsp_ptr)
);

// File: tb/art_node_lookup_bench.sv
module art_node_lookup_bench;

    logic           clk = 1'b0;
    logic           rst;
    logic           req_valid;
    logic           req_ready;
    logic [1:0]     req_kind;
    logic [4:0]     req_count;
    logic [7:0]     req_key;
    logic [127:0]   node_keys;
    logic [2047:0]  node_index;
    logic [767:0]   node_ptrs;
    logic           rsp_valid, rsp_hit, rsp_err;
    logic [15:0]    rsp_ptr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10ns clk = ~clk;

    art_node_lookup u_art_node_lookup (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_count(req_count), .req_key(req_key),
        .node_keys(node_keys), .node_index(node_index), .node_ptrs(node_ptrs),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_ptr(rsp_ptr)
    );

    typedef struct packed {
        logic [1:0]  kind;
        logic [4:0]  cnt;
        logic [7:0]  key;
        logic        hit;
        logic [15:0] ptr;
        logic        err;
    } vec_t;

    // Keys: position i holds 0x10 + 0x11*i. Pointer s is 0x1000 + s.
    // Index: k<48 -> 47-k, k=103 -> 5, k=200 -> 60, otherwise 0xFF.
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 5'd4,  8'h10, 1'b1, 16'h1000, 1'b0},  // R1 first position
        '{2'd0, 5'd4,  8'h43, 1'b1, 16'h1003, 1'b0},  // R1 last position
        '{2'd0, 5'd4,  8'h54, 1'b0, 16'h0000, 1'b0},  // R2 beyond capacity
        '{2'd0, 5'd2,  8'h32, 1'b0, 16'h0000, 1'b0},  // R2 beyond count
        '{2'd0, 5'd16, 8'h54, 1'b0, 16'h0000, 1'b0},  // R2 count clamped to 4
        '{2'd1, 5'd16, 8'h0F, 1'b1, 16'h100F, 1'b0},  // R1 position 15
        '{2'd1, 5'd10, 8'hA9, 1'b1, 16'h1009, 1'b0},  // R2 at count edge
        '{2'd1, 5'd9,  8'hA9, 1'b0, 16'h0000, 1'b0},  // R2 just outside
        '{2'd1, 5'd16, 8'h11, 1'b0, 16'h0000, 1'b0},  // R3 absent key
        '{2'd1, 5'd0,  8'h10, 1'b0, 16'h0000, 1'b0},  // R2 zero count
        '{2'd2, 5'd0,  8'd103,1'b1, 16'h1005, 1'b0},  // R5 key 103 -> slot 5
        '{2'd2, 5'd0,  8'd0,  1'b1, 16'h102F, 1'b0},  // R5 top slot
        '{2'd2, 5'd0,  8'd47, 1'b1, 16'h1000, 1'b0},  // R5 slot 0
        '{2'd2, 5'd0,  8'd100,1'b0, 16'h0000, 1'b0},  // R6 empty marker
        '{2'd2, 5'd0,  8'd200,1'b0, 16'h0000, 1'b0},  // R6 slot out of range
        '{2'd3, 5'd4,  8'h10, 1'b0, 16'h0000, 1'b1}   // R7 invalid kind
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] k);
        case (k)
            2'd2:    return "R5 R6";
            2'd3:    return "R7";
            default: return "R1 R2 R3";
        endcase
    endfunction

    task automatic run_req(input vec_t v, input string tag);
        req_kind  = v.kind;
        req_count = v.cnt;
        req_key   = v.key;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (v.kind == 2'd2) begin
            check(tag, "early valid", 32'(rsp_valid), 32'd0);
            check("R8", "ready in gap", 32'(req_ready), 32'd0);
            @(negedge clk);
        end
        check(tag, "valid", 32'(rsp_valid), 32'd1);
        check(tag, "hit", 32'(rsp_hit), 32'(v.hit));
        check(tag, "ptr", 32'(rsp_ptr), 32'(v.ptr));
        check(tag, "err", 32'(rsp_err), 32'(v.err));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(20ns * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        vec_t dv;
        for (int i = 0; i < 16; i++) node_keys[i*8 +: 8] = 8'(8'h10 + 8'h11 * i);
        for (int s = 0; s < 48; s++) node_ptrs[s*16 +: 16] = 16'(16'h1000 + s);
        for (int k = 0; k < 256; k++) begin
            if (k < 48)        node_index[k*8 +: 8] = 8'(47 - k);
            else if (k == 103) node_index[k*8 +: 8] = 8'd5;
            else if (k == 200) node_index[k*8 +: 8] = 8'd60;
            else               node_index[k*8 +: 8] = 8'hFF;
        end
        req_valid = 1'b0; req_kind = '0; req_count = '0; req_key = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "valid in reset", 32'(rsp_valid), 32'd0);
        check("R9", "ready in reset", 32'(req_ready), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "valid after reset", 32'(rsp_valid), 32'd0);
        check("R9", "ready after reset", 32'(req_ready), 32'd1);

        for (int n = 0; n < NV; n++) run_req(VECS[n], tag_of(VECS[n].kind));

        // R4: duplicate stored key, lowest position wins
        node_keys[5*8 +: 8] = 8'h32;
        node_keys[9*8 +: 8] = 8'h32;
        dv = '{2'd1, 5'd16, 8'h32, 1'b1, 16'h1002, 1'b0};
        run_req(dv, "R4");
        dv = '{2'd1, 5'd16, 8'hFE, 1'b0, 16'h0000, 1'b0};
        node_keys[2*8 +: 8] = 8'h00;
        node_keys[14*8 +: 8] = 8'h77;
        dv = '{2'd1, 5'd16, 8'h32, 1'b1, 16'h1005, 1'b0};
        run_req(dv, "R4");
        for (int i = 0; i < 16; i++) node_keys[i*8 +: 8] = 8'(8'h10 + 8'h11 * i);

        // R8: request offered in the gap is ignored
        req_kind = 2'd2; req_count = '0; req_key = 8'd103; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_kind = 2'd0; req_count = 5'd4; req_key = 8'h10;
        check("R8", "ready in gap", 32'(req_ready), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8", "wide rsp valid", 32'(rsp_valid), 32'd1);
        check("R8", "wide rsp ptr", 32'(rsp_ptr), 32'h1005);
        @(negedge clk);
        check("R8", "no rsp for ignored req", 32'(rsp_valid), 32'd0);
        check("R8", "ready restored", 32'(req_ready), 32'd1);

        // R1: back-to-back small requests each answer next cycle
        req_kind = 2'd0; req_count = 5'd4; req_key = 8'h21; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "b2b first ptr", 32'(rsp_ptr), 32'h1001);
        req_key = 8'h32;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R1", "b2b second valid", 32'(rsp_valid), 32'd1);
        check("R1", "b2b second ptr", 32'(rsp_ptr), 32'h1002);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule